// File: doc/BRIEF.md
# Bus Wait-State Ready Generator

This block is the target-side timing logic for a slow peripheral on an 8-bit, XT-style system bus. It watches the address-latch strobe and the low ten address bits. When an I/O cycle falls inside the peripheral's configured port window, it asserts a chip select. In the same clock it also starts pulling the shared ready line low, which stretches the host's bus cycle. It then counts bus clocks and lets ready go again once the count reaches three plus a programmable number of extra wait clocks.

Clock 0 is the address phase (T1), clock 1 is T2 and clock 2 is T3. Clock 3 is the first inserted wait clock (Tw), so a wait setting of zero still gives one Tw. The ready output is a pull-down enable. A 1 means this device drives the wired ready line low, and a 0 means it leaves the line alone. Several such devices can therefore share one line with a pull-up. A control state machine has three states. IDLE waits for a hit. HOLD counts while ready is pulled low. DONE waits for the end of the strobe after release. Its transitions are:

- IDLE→HOLD (start): ALE is high with an in-window address.
- HOLD→DONE (release): the counter reaches its target while a strobe is active.
- HOLD→IDLE (abort): no strobe is active in a HOLD clock.
- DONE→IDLE (finish): both strobes are inactive.

Top module: `wsr_ready_gen`

## Requirements
- R1: A hit happens only when ALE is 1 and address bits 9..0 lie in [BASE_ADDR, BASE_ADDR+PORT_COUNT-1], which defaults to 3F0h..3F7h. Address bits above bit 9 are ignored.
- R2: In the clock where a hit occurs in IDLE, `cs` and `rdy_pull_low` are both 1 in that same clock.
- R3: With wait setting W, `rdy_pull_low` is 1 in clocks 0 through 2+W, counting the hit clock as 0. It is 0 from clock 3+W on, which is W+3 clocks in all, provided a strobe stays active from clock 1.
- R4: W=0 gives exactly three pull-down clocks (T1, T2, T3), so the host inserts exactly one Tw.
- R5: The wait setting is captured in the hit clock. Changing `wait_sel` later in the cycle has no effect on the release clock.
- R6: After release, `cs` stays 1 up to and including the first clock in which both strobes `ior_n` and `iow_n` (active low) are high. It is 0 in the clock after that.
- R7: If both strobes are high in any clock from clock 1 up to release, that clock has `rdy_pull_low`=0. `cs` is 0 from the next clock, so the cycle is aborted.
- R8: `rdy_pull_low` is never 1 while `cs` is 0. After reset both outputs are 0.
- R9: An ALE pulse with an in-window address while a cycle is in HOLD or DONE does not start a new cycle and does not change the release clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale | input | 1 | Address latch strobe, high in T1 |
| addr | input | 20 | System address; bits 9..0 decoded |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| wait_sel | input | 4 | Extra wait clocks beyond the first Tw |
| cs | output | 1 | Chip select for the peripheral |
| rdy_pull_low | output | 1 | 1 = drive shared ready line low; 0 = release it |

## Verification
Two results are combinational and due in the hit clock itself: the chip select and the pull-down. The release is due exactly 3+W clocks after the hit. The deselect is due one clock after the first clock with both strobes high. The bench drives inputs on the falling edge and samples outputs one nanosecond later, still before the next rising edge. At each of these sample points a behavioural model, advanced after every rising edge, gives the expected outputs. Directed transactions also count the pull-down and select clocks per bus cycle and compare them with W+3 and W+5. An aborted cycle must give 2 pull-down and 3 select clocks, and a miss must give 0 of each.

// File: rtl/wsr_pkg.sv
`timescale 1ns/1ps
package wsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DONE = 2'd2
    } wsr_state_e;

    localparam int unsigned DEC_W = 10;
    localparam int unsigned BASE_LEAD = 3;
endpackage

// File: rtl/wsr_port_decode.sv
`timescale 1ns/1ps
module wsr_port_decode #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned DEC_W      = 10,
    parameter logic [9:0]  BASE_ADDR  = 10'h3F0,
    parameter int unsigned PORT_COUNT = 8
) (
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [DEC_W:0] LO = {1'b0, BASE_ADDR};
    localparam logic [DEC_W:0] HI = LO + (DEC_W+1)'(PORT_COUNT - 1);

    logic [DEC_W:0] port;

    always_comb begin
        port = {1'b0, addr[DEC_W-1:0]};
        hit  = ale && (port >= LO) && (port <= HI);
    end
endmodule

// File: rtl/wsr_wait_counter.sv
`timescale 1ns/1ps
module wsr_wait_counter #(
    parameter int unsigned WAIT_W = 4,
    parameter int unsigned CNT_W  = WAIT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  tgt,
    output logic              reached
);
    localparam logic [CNT_W-1:0] LEAD = CNT_W'(wsr_pkg::BASE_LEAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tgt <= LEAD;
        end else if (load) begin
            cnt <= CNT_W'(1);
            tgt <= LEAD + CNT_W'(wait_sel);
        end else if (advance) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign reached = (cnt >= tgt);
endmodule

// File: rtl/wsr_ready_gen.sv
`timescale 1ns/1ps
module wsr_ready_gen #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned WAIT_W     = 4,
    parameter logic [9:0]  BASE_ADDR  = 10'h3F0,
    parameter int unsigned PORT_COUNT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              cs,
    output logic              rdy_pull_low
);
    import wsr_pkg::*;

    localparam int unsigned CNT_W = WAIT_W + 2;

    wsr_state_e       state, state_nx;
    logic             hit, strobe, start, reached;
    logic [CNT_W-1:0] cnt, tgt;

    wsr_port_decode #(
        .ADDR_W(ADDR_W), .DEC_W(DEC_W),
        .BASE_ADDR(BASE_ADDR), .PORT_COUNT(PORT_COUNT)
    ) u_dec (
        .ale(ale), .addr(addr), .hit(hit)
    );

    assign strobe = !ior_n || !iow_n;
    assign start  = (state == ST_IDLE) && hit;

    wsr_wait_counter #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(start), .advance(state == ST_HOLD),
        .wait_sel(wait_sel),
        .cnt(cnt), .tgt(tgt), .reached(reached)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (hit)          state_nx = ST_HOLD;
            ST_HOLD: if (!strobe)      state_nx = ST_IDLE;
                     else if (reached) state_nx = ST_DONE;
            ST_DONE: if (!strobe)      state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cs           = 1'b0;
        rdy_pull_low = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cs           = start;
                rdy_pull_low = start;
            end
            ST_HOLD: begin
                cs           = 1'b1;
                rdy_pull_low = strobe && !reached;
            end
            ST_DONE: cs = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wsr_ready_chk.sv
`timescale 1ns/1ps
module wsr_ready_chk #(
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             rdy_pull_low,
    input logic             ior_n,
    input logic             iow_n,
    input logic [1:0]       state,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] tgt
);
    // R2
    sel_with_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> rdy_pull_low);
    // R8
    pull_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull_low |-> cs);
    // R3
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy_pull_low) && cs && (!ior_n || !iow_n)) |-> (cnt >= tgt));
    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1 && ior_n && iow_n) |=> (state == 2'd0 && !cs));
    // R6
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |-> !rdy_pull_low);
    // R5
    target_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd0 && $past(state) != 2'd0) |-> $stable(tgt));
endmodule

bind wsr_ready_gen wsr_ready_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rdy_pull_low(rdy_pull_low),
    .ior_n(ior_n), .iow_n(iow_n), .state(state), .cnt(cnt), .tgt(tgt)
);

// File: tb/sim_wsr_ready_gen.sv
`timescale 1ns/1ps
module sim_wsr_ready_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [19:0] addr = '0;
    logic        ior_n = 1'b1;
    logic        iow_n = 1'b1;
    logic [3:0]  wait_sel = '0;
    logic        cs, rdy_pull_low;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // behavioural reference: 0 idle, 1 holding, 2 released
    int m_st = 0, m_cnt = 0, m_tgt = 0;

    always #5 clk = ~clk;

    wsr_ready_gen u0 (
        .clk(clk), .rst_n(rst_n), .ale(ale), .addr(addr),
        .ior_n(ior_n), .iow_n(iow_n), .wait_sel(wait_sel),
        .cs(cs), .rdy_pull_low(rdy_pull_low)
    );

    function automatic bit in_win(input logic [19:0] a);
        return (a[9:0] >= 10'h3F0) && (a[9:0] <= 10'h3F7);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    int lows, sels;

    task automatic step(input logic a, input logic [19:0] ad,
                        input logic rd, input logic wr, input logic [3:0] w);
        bit st, hit, e_rdy, e_cs;
        ale = a; addr = ad; ior_n = rd; iow_n = wr; wait_sel = w;
        #1;
        st  = !rd || !wr;
        hit = a && in_win(ad);
        e_rdy = (m_st == 0 && hit) || (m_st == 1 && st && m_cnt < m_tgt);
        e_cs  = (m_st == 0 && hit) || m_st != 0;
        check("R2/R3/R7 pull", int'(rdy_pull_low), int'(e_rdy));
        check("R1/R6/R9 select", int'(cs), int'(e_cs));
        if (rdy_pull_low) lows++;
        if (cs) sels++;
        @(posedge clk);
        case (m_st)
            0: if (hit) begin m_st = 1; m_cnt = 1; m_tgt = 3 + int'(w); end
            1: if (!st) m_st = 0;
               else if (m_cnt >= m_tgt) m_st = 2;
               else m_cnt++;
            default: if (!st) m_st = 0;
        endcase
        @(negedge clk);
    endtask

    // one bus cycle: T1, then slen strobe clocks, then two quiet clocks
    task automatic txn(input logic [19:0] ad, input bit wr, input logic [3:0] w,
                       input bit mess_w, input int slen, input bit re_ale);
        lows = 0; sels = 0;
        step(1'b1, ad, 1'b1, 1'b1, w);
        for (int i = 1; i <= slen; i++) begin
            step(re_ale && i == 2, ad, wr, !wr, mess_w ? ~w : w);
        end
        step(1'b0, ad, 1'b1, 1'b1, w);
        step(1'b0, ad, 1'b1, 1'b1, w);
    endtask

    initial begin
        #2_000_000;
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset cs", int'(cs), 0);
        check("R8 reset pull", int'(rdy_pull_low), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: zero wait gives three pull clocks
        txn(20'h003F0, 1'b0, 4'd0, 1'b0, 3, 1'b0);
        check("R4 pull clocks", lows, 3);
        check("R6 select clocks", sels, 5);
        // R3: five extra waits, write strobe, top port
        txn(20'h003F7, 1'b1, 4'd5, 1'b0, 8, 1'b0);
        check("R3 pull clocks", lows, 8);
        check("R6 select clocks", sels, 10);
        // R3: maximum wait
        txn(20'h003F3, 1'b0, 4'd15, 1'b0, 18, 1'b0);
        check("R3 max pull clocks", lows, 18);
        // R1: upper address bits ignored
        txn(20'hA53F4, 1'b0, 4'd2, 1'b0, 5, 1'b0);
        check("R1 high bits ignored", lows, 5);
        // R1: just outside the window on both sides
        txn(20'h003F8, 1'b0, 4'd2, 1'b0, 5, 1'b0);
        check("R1 above window", sels, 0);
        txn(20'h003EF, 1'b1, 4'd2, 1'b0, 5, 1'b0);
        check("R1 below window", sels, 0);
        // R5: wait setting changed after T1
        txn(20'h003F1, 1'b0, 4'd1, 1'b1, 4, 1'b0);
        check("R5 captured wait", lows, 4);
        // R7: strobe ends early
        txn(20'h003F2, 1'b0, 4'd5, 1'b0, 1, 1'b0);
        check("R7 abort pull", lows, 2);
        check("R7 abort select", sels, 3);
        // R9: second ALE hit mid-cycle
        txn(20'h003F5, 1'b1, 4'd3, 1'b0, 6, 1'b1);
        check("R9 restart ignored", lows, 6);
        check("R9 select clocks", sels, 8);
        // R8: ALE hit without any following strobe never leaves the line held
        txn(20'h003F6, 1'b0, 4'd4, 1'b0, 0, 1'b0);
        check("R8 no strobe pull", lows, 1);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule